// File: doc/BRIEF.md
# Transport Packet Superframe Scrambler

This block sits between a transport packet source and a 16-parity-byte outer encoder. It accepts a byte stream of 188-byte packets, each one opened by a sync byte and marked by a packet-start flag, and returns the same stream with every non-sync byte randomized. Packets are counted in groups of eight, called superframes. The sync byte of the first packet in each superframe is sent out as its bitwise inverse, and that output byte is marked with a superframe-start flag. The other seven sync bytes pass through unchanged.

Randomization XORs each payload byte with eight bits from a 15-stage pseudo-random generator with polynomial 1 + x^14 + x^15. The generator is reloaded with a fixed pattern once per superframe, when the inverted sync is accepted. It keeps stepping through the plain sync bytes, but its output is not applied to them. After the last byte of a packet the block holds a guard interval of 16 clock cycles. During the guard it ignores its inputs and its output valid stays low, so each packet takes 204 byte times at the output and the downstream encoder can put its parity bytes in that slot. All outputs come from registers, one cycle after the accepted input.

Control is a three-state machine. WAIT_SYNC waits for a valid byte that carries the packet-start flag. The transition "sync accepted" moves it to PAYLOAD and advances the packet-in-superframe count. PAYLOAD counts accepted bytes, and the transition "last byte" moves it to GUARD. GUARD counts clock cycles, and the transition "guard done" returns it to WAIT_SYNC. A synchronous reset is the fourth transition: from any state it goes to WAIT_SYNC with both counts cleared.

Top module: `tsp_sf_scrambler`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, out_pkt_start and out_sf_start are low. The first packet accepted after reset opens a new superframe.
- R2: The sync byte of packet 1 of every 8 is output as the bitwise inverse of the input byte (0x47 becomes 0xB8), with out_pkt_start and out_sf_start both high.
- R3: The sync bytes of packets 2 to 8 of a superframe are output unchanged, with out_pkt_start high and out_sf_start low.
- R4: Each payload byte is output as input XOR eight consecutive generator bits, first bit on bit 7. Feedback is stage 14 XOR stage 15, shifted into stage 1. Payload outputs have both flags low.
- R5: When the inverted sync is accepted, the generator is loaded with 100101010000000 (stage 1 leftmost). The first payload byte of a superframe is therefore XORed with 0x03.
- R6: Each plain sync byte steps the generator eight times without applying its output.
- R7: After the 188th byte of a packet there are 16 clock cycles in which out_valid stays low and in_valid, in_start and in_data are ignored. A sync offered on the 17th cycle is accepted.
- R8: Every accepted byte appears at the output exactly one clock cycle after it is sampled, in order.
- R9: Inside a packet, a cycle with in_valid low gives no output and does not step the generator. In_start on a payload byte is ignored, and that byte is scrambled as payload.
- R10: While waiting for a sync, a valid byte without in_start is dropped: no output, and no change to the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is present |
| in_start | input | 1 | Input byte is a packet's sync byte |
| out_data | output | 8 | Sync byte (inverted or plain) or scrambled payload byte |
| out_valid | output | 1 | Output byte is present |
| out_pkt_start | output | 1 | Output byte is a sync byte |
| out_sf_start | output | 1 | Output byte is the inverted sync that opens a superframe |

## Verification
The bench keeps the default parameters: 188-byte packets, a 16-cycle guard and eight packets per superframe. Eleven packets therefore cross one superframe boundary, and the bench compares the generator reload against a sequence carried over from the previous superframe. The bench also resets the block partway through a superframe to show the counts restart. Junk bytes and start flags are offered in the guard cycles, and holes are placed inside a payload, so the guard length and the stall behaviour are tested at the exact cycle where they end.

// File: rtl/tsp_scr_pkg.sv
package tsp_scr_pkg;

    // Sequencer states: waiting for a sync, inside a packet, guard interval
    typedef enum logic [1:0] {
        ST_WAIT_SYNC = 2'd0,
        ST_PAYLOAD   = 2'd1,
        ST_GUARD     = 2'd2
    } seq_state_e;

    // Register width needed to hold a count of n (at least 1 bit)
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsp_prbs_gen.sv
module tsp_prbs_gen #(
    parameter int                  LFSR_LEN = 15,
    parameter int                  TAP_HI   = 15,
    parameter int                  TAP_LO   = 14,
    parameter logic [LFSR_LEN-1:0] SEED     = 15'h00A9,
    parameter int                  STEPS    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    output logic [STEPS-1:0] mask
);

    // reg_q[i] holds stage i+1
    logic [LFSR_LEN-1:0] reg_q;
    logic [LFSR_LEN-1:0] walk;
    logic [LFSR_LEN-1:0] reg_after;
    logic                fb;

    // Unroll STEPS shifts. The first output bit lands on the mask MSB.
    always_comb begin
        walk = reg_q;
        fb   = 1'b0;
        mask = '0;
        for (int k = 0; k < STEPS; k++) begin
            fb                = walk[TAP_HI-1] ^ walk[TAP_LO-1];
            mask[STEPS-1-k]   = fb;
            walk              = {walk[LFSR_LEN-2:0], fb};
        end
        reg_after = walk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= SEED;
        end else if (load) begin
            reg_q <= SEED;
        end else if (adv) begin
            reg_q <= reg_after;
        end
    end

endmodule

// File: rtl/tsp_pkt_sequencer.sv
module tsp_pkt_sequencer
    import tsp_scr_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int GAP_LEN = 16,
    parameter int SF_PKTS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_start,
    output logic       take_sync,
    output logic       take_body,
    output logic       sf_first,
    output seq_state_e state
);

    localparam int BW = cnt_width(PKT_LEN);
    localparam int GW = cnt_width(GAP_LEN);
    localparam int PW = cnt_width(SF_PKTS);
    localparam logic [BW-1:0] LAST_BODY = BW'(PKT_LEN - 1);
    localparam logic [GW-1:0] LAST_GAP  = GW'(GAP_LEN - 1);
    localparam logic [PW-1:0] LAST_PKT  = PW'(SF_PKTS - 1);

    seq_state_e      st_q, st_d;
    logic [BW-1:0]   byte_q, byte_d;
    logic [GW-1:0]   gap_q, gap_d;
    logic [PW-1:0]   pkt_q, pkt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_WAIT_SYNC;
            byte_q <= '0;
            gap_q  <= '0;
            pkt_q  <= '0;
        end else begin
            st_q   <= st_d;
            byte_q <= byte_d;
            gap_q  <= gap_d;
            pkt_q  <= pkt_d;
        end
    end

    // Next state and counters
    always_comb begin
        st_d   = st_q;
        byte_d = byte_q;
        gap_d  = gap_q;
        pkt_d  = pkt_q;
        unique case (st_q)
            ST_WAIT_SYNC: begin
                // sync accepted
                if (in_valid && in_start) begin
                    st_d   = ST_PAYLOAD;
                    byte_d = BW'(1);
                    pkt_d  = (pkt_q == LAST_PKT) ? '0 : pkt_q + PW'(1);
                end
            end
            ST_PAYLOAD: begin
                if (in_valid) begin
                    if (byte_q == LAST_BODY) begin
                        // last byte
                        st_d   = ST_GUARD;
                        byte_d = '0;
                        gap_d  = '0;
                    end else begin
                        byte_d = byte_q + BW'(1);
                    end
                end
            end
            ST_GUARD: begin
                if (gap_q == LAST_GAP) begin
                    // guard done
                    st_d = ST_WAIT_SYNC;
                end else begin
                    gap_d = gap_q + GW'(1);
                end
            end
            default: begin
                st_d = ST_WAIT_SYNC;
            end
        endcase
    end

    // Decoded strobes for the datapath
    always_comb begin
        take_sync = 1'b0;
        take_body = 1'b0;
        sf_first  = 1'b0;
        unique case (st_q)
            ST_WAIT_SYNC: begin
                take_sync = in_valid && in_start;
                sf_first  = in_valid && in_start && (pkt_q == '0);
            end
            ST_PAYLOAD: begin
                take_body = in_valid;
            end
            ST_GUARD: begin
                take_body = 1'b0;
            end
            default: begin
                take_sync = 1'b0;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/tsp_out_stage.sv
module tsp_out_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [BYTE_W-1:0] mask,
    input  logic              take_sync,
    input  logic              take_body,
    input  logic              sf_first,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_pkt_start,
    output logic              out_sf_start
);

    logic [BYTE_W-1:0] data_d;

    // Syncs bypass the mask. The superframe-opening sync is inverted.
    always_comb begin
        if (take_sync) begin
            data_d = sf_first ? ~in_data : in_data;
        end else if (take_body) begin
            data_d = in_data ^ mask;
        end else begin
            data_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data      <= '0;
            out_valid     <= 1'b0;
            out_pkt_start <= 1'b0;
            out_sf_start  <= 1'b0;
        end else begin
            out_data      <= data_d;
            out_valid     <= take_sync || take_body;
            out_pkt_start <= take_sync;
            out_sf_start  <= sf_first;
        end
    end

endmodule

// File: rtl/tsp_sf_scrambler.sv
module tsp_sf_scrambler
    import tsp_scr_pkg::*;
#(
    parameter int                  BYTE_W   = 8,
    parameter int                  PKT_LEN  = 188,
    parameter int                  GAP_LEN  = 16,
    parameter int                  SF_PKTS  = 8,
    parameter int                  LFSR_LEN = 15,
    parameter logic [LFSR_LEN-1:0] SEED     = 15'h00A9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_start,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_pkt_start,
    output logic              out_sf_start
);

    logic              take_sync;
    logic              take_body;
    logic              sf_first;
    seq_state_e        seq_state;
    logic [BYTE_W-1:0] mask;
    logic              gen_load;
    logic              gen_adv;

    tsp_pkt_sequencer #(
        .PKT_LEN (PKT_LEN),
        .GAP_LEN (GAP_LEN),
        .SF_PKTS (SF_PKTS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .take_sync (take_sync),
        .take_body (take_body),
        .sf_first  (sf_first),
        .state     (seq_state)
    );

    // Reload on the superframe sync. Step on plain syncs and payload.
    assign gen_load = sf_first;
    assign gen_adv  = take_body || (take_sync && !sf_first);

    tsp_prbs_gen #(
        .LFSR_LEN (LFSR_LEN),
        .TAP_HI   (LFSR_LEN),
        .TAP_LO   (LFSR_LEN - 1),
        .SEED     (SEED),
        .STEPS    (BYTE_W)
    ) u_gen (
        .clk  (clk),
        .rst  (rst),
        .load (gen_load),
        .adv  (gen_adv),
        .mask (mask)
    );

    tsp_out_stage #(
        .BYTE_W (BYTE_W)
    ) u_out (
        .clk           (clk),
        .rst           (rst),
        .in_data       (in_data),
        .mask          (mask),
        .take_sync     (take_sync),
        .take_body     (take_body),
        .sf_first      (sf_first),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_pkt_start (out_pkt_start),
        .out_sf_start  (out_sf_start)
    );

endmodule

// File: rtl/tsp_sf_scrambler_chk.sv
module tsp_sf_scrambler_chk
    import tsp_scr_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int SF_PKTS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_pkt_start,
    input logic              out_sf_start,
    input seq_state_e        seq_st
);

    localparam int PW = cnt_width(SF_PKTS);

    // Independent count of output sync bytes within a superframe
    logic [PW-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (out_pkt_start) begin
            seen_q <= (seen_q == PW'(SF_PKTS - 1)) ? '0 : seen_q + PW'(1);
        end
    end

    p_sf_period_r2: assert property (@(posedge clk) disable iff (rst)
        out_pkt_start |-> (out_sf_start == (seen_q == '0)))
        else $error("superframe marker out of period");

    p_sf_marks_r2: assert property (@(posedge clk) disable iff (rst)
        out_sf_start |-> (out_pkt_start && out_valid))
        else $error("superframe marker without sync");

    p_inverted_sync_r2: assert property (@(posedge clk) disable iff (rst)
        out_sf_start |-> (out_data == ~$past(in_data)))
        else $error("superframe sync not inverted");

    p_plain_sync_r3: assert property (@(posedge clk) disable iff (rst)
        (out_pkt_start && !out_sf_start) |-> (out_data == $past(in_data)))
        else $error("plain sync altered");

    p_guard_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_st == ST_GUARD) |=> !out_valid)
        else $error("output during guard");

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid))
        else $error("output without input one cycle earlier");

    p_hole_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_st == ST_PAYLOAD && !in_valid) |=> !out_valid)
        else $error("output for a hole in payload");

endmodule

bind tsp_sf_scrambler tsp_sf_scrambler_chk #(
    .BYTE_W  (BYTE_W),
    .SF_PKTS (SF_PKTS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_data       (in_data),
    .in_valid      (in_valid),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_pkt_start (out_pkt_start),
    .out_sf_start  (out_sf_start),
    .seq_st        (seq_state)
);

// File: tb/test_tsp_sf_scrambler.sv
module test_tsp_sf_scrambler;

    localparam int PKT_LEN = 188;
    localparam int GAP_LEN = 16;
    localparam int SF_PKTS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_pkt_start;
    logic       out_sf_start;

    always #10 clk = ~clk;

    tsp_sf_scrambler i_tsp_sf_scrambler (
        .clk           (clk),
        .rst           (rst),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_start      (in_start),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_pkt_start (out_pkt_start),
        .out_sf_start  (out_sf_start)
    );

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    typedef struct {
        logic [7:0] d;
        logic       ps;
        logic       sf;
        int         at;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Reference model of the generator, built from R4/R5
    bit m_st[1:15];
    int m_pkt = 0;

    function automatic void m_seed();
        string pat = "100101010000000";
        for (int i = 0; i < 15; i++) m_st[i+1] = (pat[i] == "1");
    endfunction

    function automatic logic [7:0] m_next8();
        logic [7:0] r;
        for (int b = 7; b >= 0; b--) begin
            bit f;
            f = m_st[14] ^ m_st[15];
            for (int j = 15; j > 1; j--) m_st[j] = m_st[j-1];
            m_st[1] = f;
            r[b] = f;
        end
        return r;
    endfunction

    task automatic fail_line(string req, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic drive(logic v, logic s, logic [7:0] d);
        @(negedge clk);
        in_valid = v;
        in_start = s;
        in_data  = d;
    endtask

    task automatic push(logic [7:0] d, logic ps, logic sf, string req);
        exp_t e;
        e.d = d; e.ps = ps; e.sf = sf; e.at = cyc + 1; e.req = req;
        q.push_back(e);
    endtask

    // One packet: sync, 187 payload bytes, then the guard
    task automatic send_pkt(input logic [7:0] sync, input int mul, input int holes,
                            input bit flag_body, input bit junk_gap);
        drive(1'b1, 1'b1, sync);
        if (m_pkt == 0) begin
            m_seed();
            push(~sync, 1'b1, 1'b1, "R2");
        end else begin
            void'(m_next8());
            push(sync, 1'b1, 1'b0, "R3/R6");
        end
        m_pkt = (m_pkt + 1) % SF_PKTS;
        for (int i = 1; i < PKT_LEN; i++) begin
            logic [7:0] d;
            if (holes != 0 && (i % holes) == 0) begin
                drive(1'b0, 1'b1, 8'hA5);   // R9 hole
            end
            d = 8'((i * mul + 7) & 8'hFF);
            if (i == 1 && mul == 0) d = 8'h00;
            drive(1'b1, flag_body && (i == 5), d);
            push(d ^ m_next8(), 1'b0, 1'b0, (i == 1) ? "R5" : ((flag_body && i == 5) ? "R9" : "R4"));
        end
        for (int g = 0; g < GAP_LEN; g++) begin
            drive(junk_gap, junk_gap, 8'h47);  // R7 ignored
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst) begin
                n_cmp++;
                if (out_valid || out_pkt_start || out_sf_start)
                    fail_line("R1", "outputs in reset", {out_valid, out_pkt_start, out_sf_start}, 0);
            end else if (out_valid) begin
                n_cmp++;
                if (q.size() == 0) begin
                    fail_line("R7/R9/R10", "unexpected output", out_data, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (out_data !== e.d)
                        fail_line(e.req, "data", out_data, e.d);
                    else if (out_pkt_start !== e.ps || out_sf_start !== e.sf)
                        fail_line(e.req, "flags", {out_pkt_start, out_sf_start}, {e.ps, e.sf});
                    else if (cyc != e.at)
                        fail_line("R8", "latency cycle", cyc, e.at);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            fail_line("WD", "watchdog cycle", cyc, 150000);
            report();
        end
    end

    initial begin
        // R1: reset
        rst = 1'b1;
        repeat (3) drive(1'b0, 1'b0, 8'h00);
        rst = 1'b0;
        drive(1'b0, 1'b0, 8'h00);
        n_cmp++;
        if (out_valid || out_pkt_start || out_sf_start)
            fail_line("R1", "outputs after reset", {out_valid, out_pkt_start, out_sf_start}, 0);

        // R10: bytes without start dropped while waiting
        repeat (3) drive(1'b1, 1'b0, 8'h47);
        drive(1'b0, 1'b0, 8'h00);

        // First superframe plus three packets of the next
        send_pkt(8'h47, 0, 0, 0, 0);
        send_pkt(8'h47, 3, 0, 0, 1);
        send_pkt(8'h47, 5, 50, 0, 0);
        send_pkt(8'h47, 7, 0, 1, 0);
        send_pkt(8'h47, 11, 0, 0, 1);
        send_pkt(8'h47, 13, 0, 0, 0);
        send_pkt(8'h47, 17, 29, 0, 0);
        send_pkt(8'h47, 19, 0, 0, 1);
        send_pkt(8'h47, 0, 0, 0, 0);
        send_pkt(8'h47, 23, 0, 0, 0);
        send_pkt(8'h47, 29, 0, 0, 0);

        // R1: reset in the middle of a superframe restarts the count
        repeat (4) drive(1'b0, 1'b0, 8'h00);
        rst = 1'b1;
        repeat (2) drive(1'b0, 1'b0, 8'h00);
        rst = 1'b0;
        m_pkt = 0;
        drive(1'b0, 1'b0, 8'h00);
        send_pkt(8'h47, 31, 0, 0, 0);
        send_pkt(8'h47, 37, 0, 0, 1);

        repeat (6) drive(1'b0, 1'b0, 8'h00);
        n_cmp++;
        if (q.size() != 0)
            fail_line("R8", "outputs still pending", q.size(), 0);
        done = 1;
        report();
    end

endmodule